// File: doc/BRIEF.md
# Inter-Core Mailbox Signalling Bank

This block holds a bank of mailbox registers that cores use to signal each other. The default bank has sixteen 32-bit mailboxes, four belonging to each of four cores. Every mailbox is reached through two word addresses on a simple register bus. A write to the raising alias ORs the written ones into the mailbox. A write to the lowering alias removes the written ones. Reading either alias returns the mailbox contents and changes nothing.

Each mailbox drives a level-sensitive active line to the interrupt router. The line is high for as long as any bit of that mailbox is set. Enabling, masking and IRQ/FIQ steering belong to the router. The bank has several request ports, two by default, so that more than one core can touch the bank in the same cycle. When a raise and a lower hit the same mailbox in one cycle, the lowering is applied first and the raising second. The raised bits therefore survive.

Each port has a small read-response state machine. It has two states. RD_IDLE means no response is due. RD_RESP means read data is on the response lines. The transitions are:
- IDLE_TO_RESP: a read request is seen while in RD_IDLE.
- RESP_TO_RESP: a back-to-back read arrives while in RD_RESP.
- RESP_TO_IDLE: no read arrives while in RD_RESP.

Top module: `mbx_bank`

## Requirements
- R1: After reset every mailbox reads as zero, every bit of `mbox_active` is 0 and every `rsp_valid` bit is 0.
- R2: A write to the raising alias ORs the ones of the write data into the addressed mailbox. Zero bits leave it unchanged. Raises from several ports to one mailbox in one cycle combine by OR.
- R3: A write to the lowering alias clears, in the addressed mailbox, each bit that is 1 in the write data. Zero bits leave it unchanged.
- R4: `mbox_active[i]` is 1 exactly when mailbox i holds a nonzero value. It follows the mailbox in the cycle after the write edge. The index i is 4×core + slot.
- R5: Core c, slot m is raised at byte address 0x80 + 16c + 4m and lowered at 0xC0 + 16c + 4m. Address bits [1:0] are ignored.
- R6: A read of either alias returns the mailbox value as held before that cycle's writes. The value appears on `rsp_data` with `rsp_valid` high in the next cycle. `rsp_valid` is low in the cycle after a cycle without a read. A read never changes a mailbox.
- R7: If a raise and a lower reach one mailbox in the same cycle, the result is (old AND NOT lower_bits) OR raise_bits.
- R8: Writes to addresses outside 0x80–0xFF change no mailbox. Reads there return zero with `rsp_valid` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_PORTS | Request present, one bit per port |
| req_write | input | NUM_PORTS | 1 = write, 0 = read, per port |
| req_addr | input | NUM_PORTS×ADDR_W | Byte address per port |
| req_wdata | input | NUM_PORTS×DATA_W | Write data per port |
| rsp_valid | output | NUM_PORTS | Read data valid, one cycle after a read |
| rsp_data | output | NUM_PORTS×DATA_W | Read data per port |
| mbox_active | output | NUM_CORES×SLOTS | Per-mailbox level, nonzero contents |

## Verification
The properties assume that every request is complete within the cycle in which `req_valid` is high. They also assume that the addresses and data are known values and that nothing else writes the mailboxes. Under those assumptions a nonzero raise must leave the line high, a full lower with no raise must drop it, and the line may only rise or fall when a raise or lower targets that mailbox. The stimulus drives every request from a clean falling-edge slot with defined values. It mixes directed cases (aliases, ignored low address bits, same-cycle raise against lower, out-of-window writes) with a long run of random two-port traffic. That traffic is confined to 0x40–0xFF, so both windows and the area just below them are exercised.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_SET  = 2'd1,
        WIN_CLR  = 2'd2
    } win_e;

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NUM_MBOX = 16,
    parameter int unsigned SET_BASE = 'h80,
    parameter int unsigned CLR_BASE = 'hC0,
    localparam int unsigned IDX_W   = $clog2(NUM_MBOX)
) (
    input  logic [ADDR_W-1:0] addr,
    output mbx_pkg::win_e     win,
    output logic [IDX_W-1:0]  idx
);
    localparam int unsigned WIN_BYTES = NUM_MBOX * 4;
    localparam logic [ADDR_W-1:0] SET_B = ADDR_W'(SET_BASE);
    localparam logic [ADDR_W-1:0] CLR_B = ADDR_W'(CLR_BASE);
    localparam logic [ADDR_W-1:0] SPAN  = ADDR_W'(WIN_BYTES);

    logic [ADDR_W-1:0] set_off;
    logic [ADDR_W-1:0] clr_off;
    logic              in_set;
    logic              in_clr;

    always_comb begin
        set_off = addr - SET_B;
        clr_off = addr - CLR_B;
        in_set  = (addr >= SET_B) && (set_off < SPAN);
        in_clr  = (addr >= CLR_B) && (clr_off < SPAN);
    end

    always_comb begin
        win = mbx_pkg::WIN_NONE;
        idx = '0;
        if (in_set) begin
            win = mbx_pkg::WIN_SET;
            idx = set_off[IDX_W+1:2];
        end else if (in_clr) begin
            win = mbx_pkg::WIN_CLR;
            idx = clr_off[IDX_W+1:2];
        end
    end
endmodule

// File: rtl/mbx_cell.sv
module mbx_cell #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_bits,
    input  logic [DATA_W-1:0] clr_bits,
    output logic [DATA_W-1:0] value,
    output logic              active
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else begin
            value <= (value & ~clr_bits) | set_bits;
        end
    end

    assign active = |value;
endmodule

// File: rtl/mbx_rd_port.sv
module mbx_rd_port #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] rd_value,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    mbx_pkg::rd_state_e state_q;
    mbx_pkg::rd_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            mbx_pkg::RD_IDLE: if (rd_req)  state_d = mbx_pkg::RD_RESP;
            mbx_pkg::RD_RESP: if (!rd_req) state_d = mbx_pkg::RD_IDLE;
            default:          state_d = mbx_pkg::RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= mbx_pkg::RD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_data <= '0;
        end else if (rd_req) begin
            rsp_data <= rd_value;
        end
    end

    assign rsp_valid = (state_q == mbx_pkg::RD_RESP);
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank #(
    parameter int unsigned NUM_PORTS = 2,
    parameter int unsigned NUM_CORES = 4,
    parameter int unsigned SLOTS     = 4,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned SET_BASE  = 'h80,
    parameter int unsigned CLR_BASE  = 'hC0,
    localparam int unsigned NUM_MBOX = NUM_CORES * SLOTS,
    localparam int unsigned IDX_W    = $clog2(NUM_MBOX)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_PORTS-1:0]                req_valid,
    input  logic [NUM_PORTS-1:0]                req_write,
    input  logic [NUM_PORTS-1:0][ADDR_W-1:0]    req_addr,
    input  logic [NUM_PORTS-1:0][DATA_W-1:0]    req_wdata,
    output logic [NUM_PORTS-1:0]                rsp_valid,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]    rsp_data,
    output logic [NUM_MBOX-1:0]                 mbox_active
);
    mbx_pkg::win_e                     dec_win [NUM_PORTS];
    logic [IDX_W-1:0]                  dec_idx [NUM_PORTS];
    logic [NUM_PORTS-1:0][DATA_W-1:0]  rd_value;
    logic [NUM_MBOX-1:0][DATA_W-1:0]   set_mask;
    logic [NUM_MBOX-1:0][DATA_W-1:0]   clr_mask;
    logic [NUM_MBOX-1:0][DATA_W-1:0]   mbox_q;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        mbx_decode #(
            .ADDR_W  (ADDR_W),
            .NUM_MBOX(NUM_MBOX),
            .SET_BASE(SET_BASE),
            .CLR_BASE(CLR_BASE)
        ) u_dec (
            .addr(req_addr[p]),
            .win (dec_win[p]),
            .idx (dec_idx[p])
        );

        assign rd_value[p] = (dec_win[p] != mbx_pkg::WIN_NONE) ? mbox_q[dec_idx[p]] : '0;

        mbx_rd_port #(.DATA_W(DATA_W)) u_rd (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_req   (req_valid[p] && !req_write[p]),
            .rd_value (rd_value[p]),
            .rsp_valid(rsp_valid[p]),
            .rsp_data (rsp_data[p])
        );
    end

    // Gather raise and lower bits from all ports; the cell applies lower before raise.
    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (req_valid[p] && req_write[p]) begin
                unique case (dec_win[p])
                    mbx_pkg::WIN_SET: set_mask[dec_idx[p]] = set_mask[dec_idx[p]] | req_wdata[p];
                    mbx_pkg::WIN_CLR: clr_mask[dec_idx[p]] = clr_mask[dec_idx[p]] | req_wdata[p];
                    default: ;
                endcase
            end
        end
    end

    for (genvar k = 0; k < NUM_MBOX; k++) begin : g_mbox
        mbx_cell #(.DATA_W(DATA_W)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_bits(set_mask[k]),
            .clr_bits(clr_mask[k]),
            .value   (mbox_q[k]),
            .active  (mbox_active[k])
        );
    end
endmodule

// File: rtl/mbx_bank_chk.sv
module mbx_bank_chk #(
    parameter int unsigned NUM_PORTS = 2,
    parameter int unsigned NUM_MBOX  = 16,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned SET_BASE  = 'h80,
    parameter int unsigned CLR_BASE  = 'hC0
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [NUM_PORTS-1:0]             req_valid,
    input logic [NUM_PORTS-1:0]             req_write,
    input logic [NUM_PORTS-1:0][ADDR_W-1:0] req_addr,
    input logic [NUM_PORTS-1:0][DATA_W-1:0] req_wdata,
    input logic [NUM_PORTS-1:0]             rsp_valid,
    input logic [NUM_MBOX-1:0]              mbox_active
);
    logic [NUM_MBOX-1:0] set_hit;
    logic [NUM_MBOX-1:0] clr_any;
    logic [NUM_MBOX-1:0] clr_full;

    always_comb begin
        set_hit  = '0;
        clr_any  = '0;
        clr_full = '0;
        for (int k = 0; k < NUM_MBOX; k++) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (req_valid[p] && req_write[p]) begin
                    if ((int'(req_addr[p]) >> 2) == int'(SET_BASE / 4) + k && req_wdata[p] != '0)
                        set_hit[k] = 1'b1;
                    if ((int'(req_addr[p]) >> 2) == int'(CLR_BASE / 4) + k && req_wdata[p] != '0)
                        clr_any[k] = 1'b1;
                    if ((int'(req_addr[p]) >> 2) == int'(CLR_BASE / 4) + k && req_wdata[p] == '1)
                        clr_full[k] = 1'b1;
                end
            end
        end
    end

    for (genvar k = 0; k < NUM_MBOX; k++) begin : g_mb
        a_r2_raise_sets_line: assert property (@(posedge clk) disable iff (!rst_n)
            set_hit[k] |=> mbox_active[k]);
        a_r3_full_lower_drops: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_full[k] && !set_hit[k]) |=> !mbox_active[k]);
        a_r4_no_fall_without_lower: assert property (@(posedge clk) disable iff (!rst_n)
            !clr_any[k] |=> !$fell(mbox_active[k]));
        a_r8_no_rise_without_raise: assert property (@(posedge clk) disable iff (!rst_n)
            !set_hit[k] |=> !$rose(mbox_active[k]));
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_pt
        a_r6_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[p] && !req_write[p]) |=> rsp_valid[p]);
        a_r6_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
            !(req_valid[p] && !req_write[p]) |=> !rsp_valid[p]);
    end
endmodule

bind mbx_bank mbx_bank_chk #(
    .NUM_PORTS(NUM_PORTS),
    .NUM_MBOX (NUM_MBOX),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .SET_BASE (SET_BASE),
    .CLR_BASE (CLR_BASE)
) u_chk (.*);

// File: tb/test_mbx_bank.sv
module test_mbx_bank;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       v = '0;
    logic [1:0]       w = '0;
    logic [1:0][7:0]  a = '0;
    logic [1:0][31:0] d = '0;
    logic [1:0]       rsp_valid;
    logic [1:0][31:0] rsp_data;
    logic [15:0]      mbox_active;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    logic [31:0] mdl [16];

    always #4 clk = ~clk;

    mbx_bank i_mbx_bank (
        .clk(clk), .rst_n(rst_n),
        .req_valid(v), .req_write(w), .req_addr(a), .req_wdata(d),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mbox_active(mbox_active)
    );

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, got, exp);
        end
    endtask

    function automatic int win_of(input logic [7:0] ad);
        if (ad >= 8'h80 && ad <= 8'hBF) return 1;
        if (ad >= 8'hC0) return 2;
        return 0;
    endfunction

    function automatic int idx_of(input logic [7:0] ad);
        return (int'(ad) % 64) / 4;
    endfunction

    task automatic step(input string tag);
        logic [31:0] nxt [16];
        logic        ev [2];
        logic [31:0] ed [2];
        logic [15:0] eact;
        @(posedge clk);
        for (int p = 0; p < 2; p++) begin
            ev[p] = v[p] && !w[p];
            ed[p] = (win_of(a[p]) != 0) ? mdl[idx_of(a[p])] : 32'h0;
        end
        nxt = mdl;
        for (int p = 0; p < 2; p++)
            if (v[p] && w[p] && win_of(a[p]) == 2) nxt[idx_of(a[p])] &= ~d[p];
        for (int p = 0; p < 2; p++)
            if (v[p] && w[p] && win_of(a[p]) == 1) nxt[idx_of(a[p])] |= d[p];
        mdl = nxt;
        @(negedge clk);
        for (int i = 0; i < 16; i++) eact[i] = (mdl[i] != 0);
        chk($sformatf("%s R4 active", tag), {16'h0, mbox_active}, {16'h0, eact});
        for (int p = 0; p < 2; p++) begin
            chk($sformatf("%s R6 rsp_valid p%0d", tag, p), {31'h0, rsp_valid[p]}, {31'h0, ev[p]});
            if (ev[p]) chk($sformatf("%s R6 rsp_data p%0d", tag, p), rsp_data[p], ed[p]);
        end
    endtask

    task automatic idle();
        v = '0; w = '0;
    endtask

    task automatic wr(input int p, input logic [7:0] ad, input logic [31:0] dt);
        v[p] = 1'b1; w[p] = 1'b1; a[p] = ad; d[p] = dt;
    endtask

    task automatic rd(input int p, input logic [7:0] ad);
        v[p] = 1'b1; w[p] = 1'b0; a[p] = ad; d[p] = '0;
    endtask

    task automatic rd_expect(input string tag, input logic [7:0] ad, input logic [31:0] exp);
        idle(); rd(0, ad); step(tag);
        chk(tag, rsp_data[0], exp);
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mdl[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 active after reset", {16'h0, mbox_active}, 32'h0);
        chk("R1 rsp_valid after reset", {30'h0, rsp_valid}, 32'h0);
        for (int i = 0; i < 16; i++) rd_expect("R1 zero after reset", 8'(8'h80 + 4 * i), 32'h0);

        // R2 / R5: core 1 slot 2 -> raise 0x98, lower 0xD8, line index 6
        idle(); wr(0, 8'h98, 32'h0000_0005); step("R2 raise");
        chk("R4 line 6 up", {31'h0, mbox_active[6]}, 32'h1);
        idle(); wr(1, 8'h98, 32'h0000_0100); step("R2 raise p1");
        rd_expect("R5 read via lower alias", 8'hD8, 32'h0000_0105);

        // R3
        idle(); wr(0, 8'hD8, 32'h0000_0004); step("R3 lower");
        rd_expect("R3 partial lower", 8'h98, 32'h0000_0101);
        idle(); wr(1, 8'hD8, 32'hFFFF_FFFF); step("R3 lower all");
        chk("R3 line 6 down", {31'h0, mbox_active[6]}, 32'h0);

        // R5: low address bits ignored; core 3 slot 3 is line 15
        idle(); wr(0, 8'hBF, 32'hA000_0001); step("R5 unaligned raise");
        rd_expect("R5 unaligned maps to 0xBC", 8'hBC, 32'hA000_0001);
        chk("R5 line 15 up", {16'h0, mbox_active}, 32'h0000_8000);
        idle(); wr(0, 8'h8C, 32'h0000_0002); step("R5 core0 slot3");
        chk("R5 line 3 up", {16'h0, mbox_active}, 32'h0000_8008);

        // R7: raise vs lower same cycle on slot 5 (0x94 / 0xD4)
        idle(); wr(0, 8'h94, 32'h0000_000F); step("R7 prep");
        idle(); wr(0, 8'h94, 32'h0000_00F0); wr(1, 8'hD4, 32'h0000_00FF); step("R7 collide");
        rd_expect("R7 raise wins", 8'hD4, 32'h0000_00F0);
        idle(); wr(0, 8'h94, 32'h0001_0000); wr(1, 8'h94, 32'h0000_0001); step("R2 two-port OR");
        rd_expect("R2 two-port OR value", 8'h94, 32'h0001_00F1);

        // R8: outside window
        idle(); wr(0, 8'h7C, 32'hFFFF_FFFF); wr(1, 8'h40, 32'hFFFF_FFFF); step("R8 stray write");
        chk("R8 lines unchanged", {16'h0, mbox_active}, 32'h0000_8028);
        rd_expect("R8 read outside", 8'h7C, 32'h0);
        rd_expect("R8 read zero addr", 8'h00, 32'h0);

        // R6: reads have no side effects, both ports, back-to-back
        idle(); rd(0, 8'h94); rd(1, 8'hD4); step("R6 dual read");
        chk("R6 dual read p1", rsp_data[1], 32'h0001_00F1);
        rd(0, 8'h94); rd(1, 8'hBC); step("R6 back-to-back");
        chk("R6 back-to-back p1", rsp_data[1], 32'hA000_0001);
        idle(); step("R6 idle");
        chk("R6 value kept after reads", {16'h0, mbox_active}, 32'h0000_8028);

        // random two-port traffic against the model
        for (int n = 0; n < 4000; n++) begin
            for (int p = 0; p < 2; p++) begin
                v[p] = ($urandom % 4) != 0;
                w[p] = ($urandom % 3) != 0;
                a[p] = 8'(8'h40 + ($urandom % 192));
                d[p] = ($urandom % 2) ? ($urandom & $urandom & $urandom) : $urandom;
            end
            step("RND R2 R3 R7 R8");
        end
        idle(); step("tail");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule